// File: doc/BRIEF.md
# Dual-Source System Clock Controller

This block picks the system clock of a small microcontroller from one of two sources. The first is a fast main oscillator. The second is a 32.768 kHz sub-oscillator. A static mode pin chooses between single-source and dual-source operation. In dual-source mode, software writes a two-bit control register. Bit 0 picks the source and bit 1 turns the main oscillator off. Two ordering rules apply to these writes:

- The main oscillator may only be turned off after the sub clock already drives the system.
- A write that breaks this order is dropped, and a sticky error flag is raised.

Source changes are glitch-free. Each clock's enable passes through a synchronizer in that clock's own domain. The enable then changes on that clock's falling edge. An enable can only rise once the other clock's enable has dropped.

The block also handles the rest of the clock tree:

- It counts four states per machine cycle on the system clock.
- It drives the enable pin of the main oscillator.
- It supplies the LCD clock. In dual-source mode this is the sub clock, which keeps running through STOP. In single-source mode it is the main clock or the main clock divided by 32, and it is cut while STOP is active.
- A STOP request halts the main oscillator and the system clock.
- A wake input restarts the main oscillator. The system clock stays silent until a programmable number of main clock cycles has passed.

The control logic runs in the main clock domain. The main clock input stands for the oscillator pad. Gating inside the block decides where that clock reaches.

Top module: `sysclk_ctrl_top`

## Requirements
- R1: After reset the register is 00. The main oscillator is enabled (`main_osc_en`=1), `src_sub`=0, `seq_err`=0, and `mc_phase`=0. The system clock runs from the main clock.
- R2: In dual-source mode, register bit 0 = 1 routes the sub clock to `sys_clk` (`src_sub`=1). Bit 0 = 0 routes the main clock (`src_sub`=0).
- R3: In dual-source mode, writing 11 while the register holds 01 drives `main_osc_en` to 0. The system clock keeps running from the sub clock.
- R4: A dual-source write is dropped if it sets bit 1 while the register's bit 0 is 0, or if it has bit 1 = 1 and bit 0 = 0. A dropped write leaves source and oscillator unchanged and sets `seq_err`. `seq_err` stays 1 until reset.
- R5: In single-source mode, register writes have no effect. `src_sub` stays 0, `main_osc_en` stays 1 and `seq_err` stays 0.
- R6: A `stop_req` pulse in a running state drives `main_osc_en` to 0 and stops `sys_clk`. This holds in both modes.
- R7: During STOP, `wake` re-enables the main oscillator and clears register bit 1, keeping bit 0. `sys_clk` stays silent while `settle_cycles` main clock cycles are counted. It then resumes from the source named by bit 0.
- R8: In dual-source mode, `lcd_clk` follows the sub clock and `lcd_on` is 1, during STOP as well.
- R9: In single-source mode, `lcd_clk` is the main clock when `lcd_div_sel`=0 and the main clock divided by 32 when it is 1. During STOP, `lcd_on` is 0 and `lcd_clk` is held low.
- R10: `mc_phase` steps 0,1,2,3,0,... on each rising edge of `sys_clk`.
- R11: The main and sub clock enables are never both active. `sys_clk` never shows a high pulse shorter than half a period of the faster source.
- R12: Writing 00 or 01 while the register holds 11 enables the main oscillator at once. The block waits `settle_cycles` main cycles (state WARM) before using the main clock, and the sub clock drives `sys_clk` meanwhile.

Control states and transitions:

| State | Meaning | Leaves to |
| --- | --- | --- |
| MAIN | Running from the main clock | SUB on a legal 01 write; STOP on `stop_req` |
| SUB | Running from the sub clock, main oscillator on | MAIN on a 00 write; SUB_MOFF on an 11 write; STOP on `stop_req` |
| SUB_MOFF | Running from the sub clock, main oscillator off | WARM on a 00 or 01 write; STOP on `stop_req` |
| WARM | Main oscillator restarting while the sub clock still drives | MAIN or SUB once the settle count is done |
| STOP | Main oscillator and system clock halted | WAKE on `wake` |
| WAKE | Main oscillator restarting, system clock gated | MAIN or SUB once the settle count is done |

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_main | input | 1 | Main oscillator clock; the control logic runs in this domain |
| clk_sub | input | 1 | Sub-oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dual_mode | input | 1 | Static: 1 = dual-source, 0 = single-source |
| lcd_div_sel | input | 1 | Single-source LCD clock: 0 = main clock, 1 = main clock / 32 |
| settle_cycles | input | SETTLE_W | Main clock cycles to wait after the main oscillator is re-enabled |
| wr_en | input | 1 | Register write strobe (main clock domain) |
| wr_data | input | 2 | Register value to write: bit 0 = use sub clock, bit 1 = main oscillator off |
| stop_req | input | 1 | One-cycle request to enter STOP |
| wake | input | 1 | Wake-up request that ends STOP |
| sys_clk | output | 1 | Selected, gated system clock |
| mc_phase | output | log2(MC_PHASES) | Machine-cycle state counter |
| main_osc_en | output | 1 | Enable for the main oscillator |
| src_sub | output | 1 | Sub clock currently gated onto `sys_clk` |
| lcd_clk | output | 1 | LCD frame clock source |
| lcd_on | output | 1 | LCD clock active |
| seq_err | output | 1 | Sticky flag for a dropped, mis-ordered register write |

## Verification
Some properties are checked on every cycle:

- The two clock enables are mutually exclusive.
- The error flag is sticky, and it only rises after a write.
- The oscillator enable only falls after a STOP request or a write.
- The machine-cycle counter advances by one on every system clock edge.
- Single-source mode never selects the sub clock.

Other behaviour needs the bench's scenarios, which count clock edges over fixed windows: the actual frequency reaching `sys_clk` and `lcd_clk`, the silent interval during settling, the clean shape of pulses around a source change, and the order of events in the STOP/wake and restart-from-WARM sequences.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    typedef enum logic [2:0] {
        ST_MAIN     = 3'd0,
        ST_SUB      = 3'd1,
        ST_SUB_MOFF = 3'd2,
        ST_WARM     = 3'd3,
        ST_STOP     = 3'd4,
        ST_WAKE     = 3'd5
    } clk_state_e;

    localparam int CTL_W    = 2;
    localparam int BIT_SUB  = 0;
    localparam int BIT_MOFF = 1;

endpackage

// File: rtl/sysclk_ctrl_fsm.sv
module sysclk_ctrl_fsm
    import sysclk_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dual_mode,
    input  logic                   wr_en,
    input  logic [CTL_W-1:0]       wr_data,
    input  logic                   stop_req,
    input  logic                   wake,
    input  logic [SETTLE_W-1:0]    settle_cycles,
    output logic                   osc_en,
    output logic                   run_en,
    output logic                   sel_sub,
    output logic                   seq_err
);

    clk_state_e           state_q, state_d;
    logic [CTL_W-1:0]     ctl_q, ctl_d;
    logic                 err_q, err_d;
    logic [SETTLE_W-1:0]  cnt_q, cnt_d;
    logic                 wr_bad;
    logic                 settle_done;

    // Stable state implied by a register value
    function automatic clk_state_e target_of(input logic [CTL_W-1:0] v);
        if (v[BIT_MOFF])     return ST_SUB_MOFF;
        else if (v[BIT_SUB]) return ST_SUB;
        else                 return ST_MAIN;
    endfunction

    // Next-state and register update
    always_comb begin
        state_d     = state_q;
        ctl_d       = ctl_q;
        err_d       = err_q;
        cnt_d       = cnt_q;
        // Main may only stop when the new value keeps sub selected
        // and sub was already selected before this write
        wr_bad      = wr_data[BIT_MOFF] && (!wr_data[BIT_SUB] || !ctl_q[BIT_SUB]);
        settle_done = (cnt_q >= settle_cycles);
        unique case (state_q)
            ST_MAIN, ST_SUB, ST_SUB_MOFF: begin
                if (stop_req) begin
                    state_d = ST_STOP;
                end else if (wr_en && dual_mode) begin
                    if (wr_bad) begin
                        err_d = 1'b1;
                    end else begin
                        ctl_d = wr_data;
                        if (ctl_q[BIT_MOFF] && !wr_data[BIT_MOFF]) begin
                            state_d = ST_WARM;
                            cnt_d   = '0;
                        end else begin
                            state_d = target_of(wr_data);
                        end
                    end
                end
            end
            ST_WARM: begin
                if (settle_done) state_d = target_of(ctl_q);
                else             cnt_d   = cnt_q + 1'b1;
            end
            ST_STOP: begin
                if (wake) begin
                    state_d         = ST_WAKE;
                    ctl_d[BIT_MOFF] = 1'b0;
                    cnt_d           = '0;
                end
            end
            ST_WAKE: begin
                if (settle_done) state_d = target_of(ctl_q);
                else             cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = ST_MAIN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MAIN;
            ctl_q   <= '0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
            err_q   <= err_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_en  <= 1'b1;
            run_en  <= 1'b1;
            sel_sub <= 1'b0;
        end else begin
            unique case (state_d)
                ST_MAIN:     begin osc_en <= 1'b1; run_en <= 1'b1; sel_sub <= 1'b0; end
                ST_SUB:      begin osc_en <= 1'b1; run_en <= 1'b1; sel_sub <= 1'b1; end
                ST_SUB_MOFF: begin osc_en <= 1'b0; run_en <= 1'b1; sel_sub <= 1'b1; end
                ST_WARM:     begin osc_en <= 1'b1; run_en <= 1'b1; sel_sub <= 1'b1; end
                ST_STOP:     begin osc_en <= 1'b0; run_en <= 1'b0; sel_sub <= 1'b0; end
                ST_WAKE:     begin osc_en <= 1'b1; run_en <= 1'b0; sel_sub <= 1'b0; end
                default:     begin osc_en <= 1'b1; run_en <= 1'b1; sel_sub <= 1'b0; end
            endcase
        end
    end

    assign seq_err = err_q;

endmodule

// File: rtl/sysclk_gf_mux.sv
module sysclk_gf_mux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_main,
    input  logic clk_sub,
    input  logic rst_n,
    input  logic want_main,
    input  logic want_sub,
    output logic main_on,
    output logic sub_on,
    output logic sys_clk
);

    localparam int N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic         want_sub_q;
    logic [N-1:0] m_sync;
    logic [N-1:0] s_sync;

    // Launch the sub request from a flop before it crosses domains
    always_ff @(posedge clk_main or negedge rst_n) begin
        if (!rst_n) want_sub_q <= 1'b0;
        else        want_sub_q <= want_sub;
    end

    always_ff @(posedge clk_main or negedge rst_n) begin
        if (!rst_n) m_sync <= '0;
        else        m_sync <= {m_sync[N-2:0], want_main & ~sub_on};
    end

    always_ff @(negedge clk_main or negedge rst_n) begin
        if (!rst_n) main_on <= 1'b0;
        else        main_on <= m_sync[N-1];
    end

    always_ff @(posedge clk_sub or negedge rst_n) begin
        if (!rst_n) s_sync <= '0;
        else        s_sync <= {s_sync[N-2:0], want_sub_q & ~main_on};
    end

    always_ff @(negedge clk_sub or negedge rst_n) begin
        if (!rst_n) sub_on <= 1'b0;
        else        sub_on <= s_sync[N-1];
    end

    assign sys_clk = (clk_main & main_on) | (clk_sub & sub_on);

endmodule

// File: rtl/sysclk_phase_cnt.sv
module sysclk_phase_cnt #(
    parameter int PHASES = 4,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase
);

    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

endmodule

// File: rtl/sysclk_ctrl_top.sv
module sysclk_ctrl_top #(
    parameter int SETTLE_W    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MC_PHASES   = 4,
    parameter int LCD_DIV     = 32
) (
    input  logic                          clk_main,
    input  logic                          clk_sub,
    input  logic                          rst_n,
    input  logic                          dual_mode,
    input  logic                          lcd_div_sel,
    input  logic [SETTLE_W-1:0]           settle_cycles,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_data,
    input  logic                          stop_req,
    input  logic                          wake,
    output logic                          sys_clk,
    output logic [$clog2(MC_PHASES)-1:0]  mc_phase,
    output logic                          main_osc_en,
    output logic                          src_sub,
    output logic                          lcd_clk,
    output logic                          lcd_on,
    output logic                          seq_err
);

    localparam int PHASE_W = $clog2(MC_PHASES);
    localparam int DIV_W   = $clog2(LCD_DIV);

    logic             run_en;
    logic             sel_sub;
    logic             want_main;
    logic             want_sub;
    logic             main_on_w;
    logic             sub_on_w;
    logic [DIV_W-1:0] div_q;
    logic             lcd_gate;
    logic             lcd_src_single;

    sysclk_ctrl_fsm #(.SETTLE_W(SETTLE_W)) fsm_i (
        .clk           (clk_main),
        .rst_n         (rst_n),
        .dual_mode     (dual_mode),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .stop_req      (stop_req),
        .wake          (wake),
        .settle_cycles (settle_cycles),
        .osc_en        (main_osc_en),
        .run_en        (run_en),
        .sel_sub       (sel_sub),
        .seq_err       (seq_err)
    );

    assign want_main = run_en & ~sel_sub;
    assign want_sub  = run_en &  sel_sub;

    sysclk_gf_mux #(.SYNC_STAGES(SYNC_STAGES)) mux_i (
        .clk_main  (clk_main),
        .clk_sub   (clk_sub),
        .rst_n     (rst_n),
        .want_main (want_main),
        .want_sub  (want_sub),
        .main_on   (main_on_w),
        .sub_on    (sub_on_w),
        .sys_clk   (sys_clk)
    );

    sysclk_phase_cnt #(.PHASES(MC_PHASES)) phase_i (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .phase (mc_phase)
    );

    assign src_sub = sub_on_w;

    // Main clock divider for the single-source LCD option
    always_ff @(posedge clk_main or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // LCD gate changes while the main clock is low
    always_ff @(negedge clk_main or negedge rst_n) begin
        if (!rst_n) lcd_gate <= 1'b0;
        else        lcd_gate <= run_en;
    end

    assign lcd_src_single = lcd_div_sel ? div_q[DIV_W-1] : clk_main;
    assign lcd_clk        = dual_mode ? clk_sub : (lcd_gate & lcd_src_single);
    assign lcd_on         = dual_mode | lcd_gate;

    logic [PHASE_W-1:0] unused_phase_w;
    assign unused_phase_w = mc_phase;

endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk #(
    parameter int PHASES = 4,
    parameter int PW = $clog2(PHASES)
) (
    input logic          clk_main,
    input logic          sys_clk,
    input logic          rst_n,
    input logic          dual_mode,
    input logic          wr_en,
    input logic          stop_req,
    input logic          main_osc_en,
    input logic          src_sub,
    input logic          main_on,
    input logic          seq_err,
    input logic [PW-1:0] mc_phase
);

    logic seen_q;

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R11
    gate_excl_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
        !(main_on && src_sub));

    // R4
    err_sticky_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
        seq_err |=> seq_err);

    // R4
    err_cause_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
        $rose(seq_err) |-> $past(wr_en));

    // R5
    single_main_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
        !dual_mode |-> (!src_sub && !seq_err));

    // R3
    osc_off_cause_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
        $fell(main_osc_en) |-> ($past(stop_req) || $past(wr_en)));

    // R10
    phase_step_chk: assert property (@(posedge sys_clk) disable iff (!rst_n || !seen_q)
        ($past(mc_phase) == PW'(PHASES - 1)) ? (mc_phase == '0)
                                             : (mc_phase == $past(mc_phase) + 1'b1));

endmodule

bind sysclk_ctrl_top sysclk_ctrl_chk #(.PHASES(MC_PHASES)) chk_i (
    .clk_main    (clk_main),
    .sys_clk     (sys_clk),
    .rst_n       (rst_n),
    .dual_mode   (dual_mode),
    .wr_en       (wr_en),
    .stop_req    (stop_req),
    .main_osc_en (main_osc_en),
    .src_sub     (src_sub),
    .main_on     (main_on_w),
    .seq_err     (seq_err),
    .mc_phase    (mc_phase)
);

// File: tb/sysclk_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module sysclk_ctrl_top_tb_top;

    logic       clk_main = 1'b0;
    logic       clk_sub  = 1'b0;
    logic       rst_n    = 1'b0;
    logic       dual_mode = 1'b1;
    logic       lcd_div_sel = 1'b0;
    logic [7:0] settle_cycles = 8'd8;
    logic       wr_en = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic       stop_req = 1'b0;
    logic       wake = 1'b0;
    logic       sys_clk;
    logic [1:0] mc_phase;
    logic       main_osc_en;
    logic       src_sub;
    logic       lcd_clk;
    logic       lcd_on;
    logic       seq_err;

    int checks   = 0;
    int failures = 0;
    int sys_edges = 0;
    int lcd_edges = 0;
    bit done = 1'b0;

    always #2  clk_main = ~clk_main;
    always #20 clk_sub  = ~clk_sub;

    always @(posedge sys_clk) sys_edges = sys_edges + 1;
    always @(posedge lcd_clk) lcd_edges = lcd_edges + 1;

    sysclk_ctrl_top dut_i (
        .clk_main      (clk_main),
        .clk_sub       (clk_sub),
        .rst_n         (rst_n),
        .dual_mode     (dual_mode),
        .lcd_div_sel   (lcd_div_sel),
        .settle_cycles (settle_cycles),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .stop_req      (stop_req),
        .wake          (wake),
        .sys_clk       (sys_clk),
        .mc_phase      (mc_phase),
        .main_osc_en   (main_osc_en),
        .src_sub       (src_sub),
        .lcd_clk       (lcd_clk),
        .lcd_on        (lcd_on),
        .seq_err       (seq_err)
    );

    // {wr_data[1:0], exp_err, exp_src_sub, exp_osc_en}, dual-source, walked in order
    localparam logic [4:0] VEC [10] = '{
        5'b01_0_1_1, 5'b11_0_1_0, 5'b01_0_1_1, 5'b00_0_0_1, 5'b11_1_0_1,
        5'b10_1_0_1, 5'b01_1_1_1, 5'b10_1_1_1, 5'b11_1_1_0, 5'b00_1_0_1
    };

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_main(input int n);
        repeat (n) @(negedge clk_main);
    endtask

    task automatic measure(input int n, output int s, output int l);
        int s0 = sys_edges;
        int l0 = lcd_edges;
        wait_main(n);
        s = sys_edges - s0;
        l = lcd_edges - l0;
    endtask

    task automatic reg_write(input logic [1:0] v);
        @(negedge clk_main);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk_main);
        wr_en = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk_main); stop_req = 1'b1;
        @(negedge clk_main); stop_req = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk_main); wake = 1'b1;
        @(negedge clk_main); wake = 1'b0;
    endtask

    task automatic do_reset(input logic dual);
        @(negedge clk_main);
        rst_n = 1'b0;
        dual_mode = dual;
        wait_main(5);
        rst_n = 1'b1;
        wait_main(60);
    endtask

    task automatic min_high(input int steps, output int minrun);
        int  run = 0;
        bit  seen_low = 1'b0;
        minrun = 1000;
        #0.25;
        for (int i = 0; i < steps; i++) begin
            #0.5;
            if (sys_clk) run++;
            else begin
                if (seen_low && run > 0 && run < minrun) minrun = run;
                run = 0;
                seen_low = 1'b1;
            end
        end
    endtask

    initial begin
        int s, l, prev, mr;

        // R1: reset state
        wait_main(3);
        chk_eq("R1 mc_phase in reset", int'(mc_phase), 0);
        rst_n = 1'b1;
        wait_main(60);
        chk_eq("R1 main_osc_en", int'(main_osc_en), 1);
        chk_eq("R1 src_sub", int'(src_sub), 0);
        chk_eq("R1 seq_err", int'(seq_err), 0);
        measure(100, s, l);
        chk_rng("R1 sys_clk from main", s, 95, 101);

        // R10: phase sequence
        @(negedge sys_clk);
        prev = int'(mc_phase);
        for (int i = 0; i < 8; i++) begin
            @(negedge sys_clk);
            chk_eq("R10 phase step", int'(mc_phase), (prev + 1) % 4);
            prev = int'(mc_phase);
        end

        // R2 R3 R4: vector table, dual-source
        for (int i = 0; i < 10; i++) begin
            string tag;
            logic [4:0] e = VEC[i];
            tag = e[2] ? "R4" : (e[4] ? "R3" : "R2");
            reg_write(e[4:3]);
            wait_main(150);
            chk_eq({tag, " seq_err"}, int'(seq_err), int'(e[2]));
            chk_eq({tag, " src_sub"}, int'(src_sub), int'(e[1]));
            chk_eq({tag, " main_osc_en"}, int'(main_osc_en), int'(e[0]));
            measure(100, s, l);
            if (e[1]) chk_rng({tag, " sys_clk from sub"}, s, 8, 11);
            else      chk_rng({tag, " sys_clk from main"}, s, 95, 101);
        end

        // R12: restart from 11 keeps sub until settle ends
        settle_cycles = 8'd40;
        do_reset(1'b1);
        reg_write(2'b01); wait_main(150);
        reg_write(2'b11); wait_main(150);
        reg_write(2'b00);
        wait_main(10);
        chk_eq("R12 osc re-enabled", int'(main_osc_en), 1);
        chk_eq("R12 still on sub", int'(src_sub), 1);
        measure(20, s, l);
        chk_rng("R12 sub clock during warm", s, 1, 3);
        wait_main(150);
        chk_eq("R12 switched to main", int'(src_sub), 0);

        // R11: clean pulses around a sub->main switch
        settle_cycles = 8'd8;
        reg_write(2'b01); wait_main(150);
        reg_write(2'b00);
        min_high(800, mr);
        chk_rng("R11 shortest high pulse (0.5ns samples)", mr, 3, 1000);
        chk_eq("R11 ended on main", int'(src_sub), 0);

        // R6 R7 R8: STOP and wake in dual-source mode
        settle_cycles = 8'd20;
        do_reset(1'b1);
        pulse_stop();
        wait_main(30);
        chk_eq("R6 osc off in stop", int'(main_osc_en), 0);
        measure(100, s, l);
        chk_eq("R6 sys_clk silent in stop", s, 0);
        chk_rng("R8 lcd runs from sub in stop", l, 8, 11);
        chk_eq("R8 lcd_on in stop", int'(lcd_on), 1);
        pulse_wake();
        wait_main(8);
        chk_eq("R7 osc on after wake", int'(main_osc_en), 1);
        measure(10, s, l);
        chk_eq("R7 sys_clk gated while settling", s, 0);
        wait_main(100);
        measure(100, s, l);
        chk_rng("R7 sys_clk resumes from main", s, 95, 101);

        // R7: wake from 11 clears bit 1, keeps sub
        reg_write(2'b01); wait_main(150);
        reg_write(2'b11); wait_main(150);
        pulse_stop(); wait_main(30);
        pulse_wake(); wait_main(200);
        chk_eq("R7 osc on after wake from 11", int'(main_osc_en), 1);
        chk_eq("R7 sub kept after wake", int'(src_sub), 1);

        // R5 R9 R6: single-source mode
        settle_cycles = 8'd8;
        lcd_div_sel = 1'b0;
        do_reset(1'b0);
        measure(100, s, l);
        chk_rng("R9 lcd from main", l, 95, 101);
        lcd_div_sel = 1'b1;
        wait_main(5);
        measure(128, s, l);
        chk_rng("R9 lcd from main/32", l, 3, 5);
        reg_write(2'b01); wait_main(100);
        chk_eq("R5 src_sub after write 01", int'(src_sub), 0);
        chk_eq("R5 seq_err after write 01", int'(seq_err), 0);
        reg_write(2'b11); wait_main(100);
        chk_eq("R5 osc after write 11", int'(main_osc_en), 1);
        chk_eq("R5 seq_err after write 11", int'(seq_err), 0);
        measure(100, s, l);
        chk_rng("R5 sys_clk stays on main", s, 95, 101);
        pulse_stop(); wait_main(30);
        chk_eq("R6 single osc off", int'(main_osc_en), 0);
        chk_eq("R9 lcd_on off in stop", int'(lcd_on), 0);
        measure(100, s, l);
        chk_eq("R9 lcd silent in stop", l, 0);
        chk_eq("R6 single sys_clk silent", s, 0);
        pulse_wake(); wait_main(100);
        chk_eq("R9 lcd_on after wake", int'(lcd_on), 1);
        chk_eq("R7 single osc after wake", int'(main_osc_en), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule